// File: doc/BRIEF.md
# Stereo Serial Audio Word Transmitter

This block takes a left and a right sample and places them, MSB first, on one serial data line. Each frame is 128 ticks of an internal sample-clock enable long and is divided into 64 bit slots. Slots 0 to 31 form the left half-frame and slots 32 to 63 the right half-frame. The bit clock runs at half the enable rate. A frame sync marks the left half. The block can generate the sync and bit clock itself (master), or follow copies of them supplied by another device (slave). In slave mode each input is resynchronised to the internal clock before it is used.

Four mode bits can be set in any combination:
- sync phase: rising one slot early, or together with the first data bit;
- word placement: at the start or at the end of each half-frame;
- idle handling: drive the line low, or release it;
- direction of sync and bit clock.

When two slave transmitters share a data line, one is set to each placement and both release the line when idle. New samples are written into a staging register at any time. They are copied into a holding register only at a frame boundary, so both words of a frame always come from the same sample pair.

Top module: `stereo_ser_tx`

## Requirements
- R1: While rst_n is low: slot is 0 and phase is 0; bclk_out is 1; sync_out is 1; sdo is 0; both held words are zero.
- R2: In master mode, bclk_out toggles on every clock with ce high and holds its value when ce is low. It is 1 in the first of the two ce ticks of each slot.
- R3: The slot advances by one on each bit-clock rising edge and wraps from 63 to 0. Each frame is 64 slots, which is 128 ce ticks in master mode. sdo_oe is 1 during the 16 data slots of each half-frame.
- R4: With mode_sync_coinc=1, sync_out is 1 in slots 0..31 and 0 elsewhere. With mode_sync_coinc=0, sync_out is 1 in slot 63 and in slots 0..30, so it rises one slot before the first left bit.
- R5: Each word is sent MSB first. Bit 15 goes in the first data slot of the word. The left word goes in slots 0..31 and the right word in slots 32..63.
- R6: mode_rjust=0 puts the word at half-frame positions 0..15. mode_rjust=1 puts it at positions 16..31.
- R7: A load pulse writes left_in and right_in into the staging register. The held words are updated from the staging register only when the slot wraps to 0. A load in mid-frame therefore appears from the next frame on, and the first frame after reset sends zeros.
- R8: In the 16 idle slots of each half-frame: mode_drive_low=1 gives sdo_oe=1 with sdo=0; mode_drive_low=0 gives sdo_oe=0.
- R9: In master mode, sync_oe and bclk_oe are 1 and sync_in and bclk_in have no effect. In slave mode, sync_oe and bclk_oe are 0.
- R10: In slave mode, with ce high, each input passes through two synchronising flops and an edge register. After the clock edge that samples a bclk_in rise, the slot advances on the second following edge.
- R11: In slave mode, a detected sync_in rise sets the slot, on that bit-clock rise or the next one, to 0 (mode_sync_coinc=1) or 63 (mode_sync_coinc=0), whatever the count was. Setting it to 0 also loads the held words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Internal sample-clock enable |
| load | input | 1 | Write left_in/right_in into the staging register |
| left_in | input | 16 | Left sample |
| right_in | input | 16 | Right sample |
| mode_slave | input | 1 | 1: follow external sync and bit clock |
| mode_sync_coinc | input | 1 | 1: sync rises with the first data bit |
| mode_rjust | input | 1 | 1: word at the end of each half-frame |
| mode_drive_low | input | 1 | 1: drive low when idle, 0: release |
| sync_in | input | 1 | External frame sync (slave) |
| bclk_in | input | 1 | External bit clock (slave) |
| sdo | output | 1 | Serial data |
| sdo_oe | output | 1 | Serial data output enable |
| sync_out | output | 1 | Generated frame sync |
| sync_oe | output | 1 | Frame sync output enable |
| bclk_out | output | 1 | Generated bit clock |
| bclk_oe | output | 1 | Bit clock output enable |

## Verification
The assertions check several properties on every cycle:
- in master mode the slot steps by exactly one per bit;
- the bit clock toggles on every enabled tick;
- the held words change only at a wrap;
- in left-justified mode, a sync rise lines up with the start of a word (coincident phase) or falls in an idle slot (early phase).

Other behaviour can only be shown by the bench scenarios, which compare every bit position against a model built from the requirements:
- exact bit order and slot placement under each combination of modes;
- a load in mid-frame taking effect at the next frame;
- the idle drive;
- the latency of the slave resynchroniser;
- realignment of the slot count to a sync that arrives late.

// File: rtl/stx_pkg.sv
package stx_pkg;
  typedef struct packed {
    logic slave;
    logic sync_coinc;
    logic rjust;
    logic drive_low;
  } stx_mode_t;
endpackage

// File: rtl/stx_sync2.sv
module stx_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic d,
  output logic rise
);
  // [0] first stage, [1] synchronised value, [2] previous synchronised value
  logic [2:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (ce) sh_d = {sh_q[1:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = ce & sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/stx_timing.sv
module stx_timing #(
  parameter int HALF_SLOTS = 32,
  parameter int SLOT_W     = $clog2(2 * HALF_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              slave,
  input  logic              sync_coinc,
  input  logic              bclk_rise,
  input  logic              sync_rise,
  output logic [SLOT_W-1:0] slot,
  output logic              phase,
  output logic              wrap
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = '1;

  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              phase_q, phase_d;
  logic              pend_q, pend_d;
  logic              advance, realign;

  always_comb begin
    advance = slave ? bclk_rise : (ce & phase_q);
    realign = slave & advance & (sync_rise | pend_q);

    slot_d = slot_q;
    if (advance) slot_d = realign ? (sync_coinc ? '0 : LAST_SLOT) : slot_q + 1'b1;

    phase_d = phase_q;
    if (slave)   phase_d = 1'b0;
    else if (ce) phase_d = ~phase_q;

    pend_d = pend_q;
    if (!slave || realign)                 pend_d = 1'b0;
    else if (sync_rise && !advance)        pend_d = 1'b1;

    wrap = advance & (slot_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      phase_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      slot_q  <= slot_d;
      phase_q <= phase_d;
      pend_q  <= pend_d;
    end
  end

  assign slot  = slot_q;
  assign phase = phase_q;

  assert_slot_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave && ce && phase_q) |=> (slot_q == $past(slot_q) + 1'b1));
endmodule

// File: rtl/stx_dout.sv
module stx_dout #(
  parameter int WORD_W     = 16,
  parameter int HALF_SLOTS = 32,
  parameter int SLOT_W     = $clog2(2 * HALF_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] left_in,
  input  logic [WORD_W-1:0] right_in,
  input  logic              wrap,
  input  logic [SLOT_W-1:0] slot,
  input  logic              rjust,
  input  logic              drive_low,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int HALF_W = $clog2(HALF_SLOTS);
  localparam int IDX_W  = $clog2(WORD_W);
  localparam logic [HALF_W-1:0] OFF_R = HALF_W'(HALF_SLOTS - WORD_W);

  logic [WORD_W-1:0] stage_q [2];
  logic [WORD_W-1:0] hold_q  [2];
  logic [WORD_W-1:0] chan_in [2];

  assign chan_in[0] = left_in;
  assign chan_in[1] = right_in;

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic [WORD_W-1:0] stage_d, hold_d;
    always_comb begin
      stage_d = load ? chan_in[ch] : stage_q[ch];
      hold_d  = wrap ? stage_q[ch] : hold_q[ch];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[ch] <= '0;
        hold_q[ch]  <= '0;
      end else begin
        stage_q[ch] <= stage_d;
        hold_q[ch]  <= hold_d;
      end
    end
  end

  logic [HALF_W-1:0] pos, rel;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] word;
  logic              active;

  always_comb begin
    pos    = slot[HALF_W-1:0];
    rel    = pos - (rjust ? OFF_R : '0);
    active = ({1'b0, rel} < (HALF_W+1)'(WORD_W));
    idx    = IDX_W'(WORD_W - 1) - rel[IDX_W-1:0];
    word   = slot[SLOT_W-1] ? hold_q[1] : hold_q[0];
    sdo    = active & word[idx];
    sdo_oe = active | drive_low;
  end

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(hold_q[0]) && $stable(hold_q[1])));
endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx #(
  parameter int WORD_W     = 16,
  parameter int HALF_SLOTS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              load,
  input  logic [WORD_W-1:0] left_in,
  input  logic [WORD_W-1:0] right_in,
  input  logic              mode_slave,
  input  logic              mode_sync_coinc,
  input  logic              mode_rjust,
  input  logic              mode_drive_low,
  input  logic              sync_in,
  input  logic              bclk_in,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              sync_out,
  output logic              sync_oe,
  output logic              bclk_out,
  output logic              bclk_oe
);
  import stx_pkg::*;
  localparam int SLOT_W = $clog2(2 * HALF_SLOTS);

  stx_mode_t mode;
  assign mode = '{slave: mode_slave, sync_coinc: mode_sync_coinc,
                  rjust: mode_rjust, drive_low: mode_drive_low};

  // index 0: sync, index 1: bit clock
  logic [1:0] ext_pins, ext_rise;
  assign ext_pins = {bclk_in, sync_in};

  for (genvar gi = 0; gi < 2; gi++) begin : g_resync
    stx_sync2 u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .ce   (ce),
      .d    (ext_pins[gi]),
      .rise (ext_rise[gi])
    );
  end

  logic [SLOT_W-1:0] slot, slot_adj;
  logic              phase, wrap;

  stx_timing #(.HALF_SLOTS(HALF_SLOTS), .SLOT_W(SLOT_W)) u_timing (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce        (ce),
    .slave     (mode.slave),
    .sync_coinc(mode.sync_coinc),
    .bclk_rise (ext_rise[1]),
    .sync_rise (ext_rise[0]),
    .slot      (slot),
    .phase     (phase),
    .wrap      (wrap)
  );

  stx_dout #(.WORD_W(WORD_W), .HALF_SLOTS(HALF_SLOTS), .SLOT_W(SLOT_W)) u_dout (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .left_in  (left_in),
    .right_in (right_in),
    .wrap     (wrap),
    .slot     (slot),
    .rjust    (mode.rjust),
    .drive_low(mode.drive_low),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe)
  );

  always_comb begin
    slot_adj = slot + {{(SLOT_W-1){1'b0}}, ~mode.sync_coinc};
    sync_out = ~slot_adj[SLOT_W-1];
    bclk_out = ~phase;
    sync_oe  = ~mode.slave;
    bclk_oe  = ~mode.slave;
  end

  assert_bclk_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_slave && ce) |=> (bclk_out != $past(bclk_out)));

  assert_coinc_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_slave && mode_sync_coinc && !mode_rjust && !mode_drive_low && $rose(sync_out))
      |-> sdo_oe);

  assert_early_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_slave && !mode_sync_coinc && !mode_rjust && !mode_drive_low && $rose(sync_out))
      |-> !sdo_oe);
endmodule

// File: tb/stereo_ser_tx_tb.sv
module stereo_ser_tx_tb;
  logic clk = 1'b0;
  logic rst_n, ce, load;
  logic [15:0] left_in, right_in;
  logic mode_slave, mode_sync_coinc, mode_rjust, mode_drive_low;
  logic sync_in, bclk_in;
  logic sdo, sdo_oe, sync_out, sync_oe, bclk_out, bclk_oe;

  always #5 clk = ~clk;

  stereo_ser_tx u_dut (.*);

  int n_chk = 0, n_bad = 0;
  int c;
  logic [15:0] sL, sR, hL, hR;

  // entry: {coinc, rjust, drive_low, left, right}
  localparam logic [34:0] VECS [4] = '{
    {3'b100, 16'hA5C3, 16'h3C5A},
    {3'b011, 16'h8001, 16'h7FFE},
    {3'b101, 16'hFFFF, 16'h0001},
    {3'b010, 16'h1357, 16'hECA8}
  };

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b (c=%0d)", req, act, exp, c);
    end
  endtask

  function automatic logic e_sync(int s, logic coinc);
    return coinc ? (s < 32) : (((s + 1) % 64) < 32);
  endfunction

  function automatic logic e_act(int s, logic rj);
    int p = s % 32;
    int off = rj ? 16 : 0;
    return (p >= off) && (p < off + 16);
  endfunction

  function automatic logic e_bit(int s, logic rj, logic [15:0] l, logic [15:0] r);
    int p = s % 32;
    int off = rj ? 16 : 0;
    if (!e_act(s, rj)) return 1'b0;
    return (s < 32) ? l[15 - (p - off)] : r[15 - (p - off)];
  endfunction

  task automatic do_reset(logic sl, logic co, logic rj, logic dl);
    rst_n = 1'b0; ce = 1'b1; load = 1'b0; left_in = '0; right_in = '0;
    sync_in = 1'b0; bclk_in = 1'b0;
    mode_slave = sl; mode_sync_coinc = co; mode_rjust = rj; mode_drive_low = dl;
    repeat (3) @(negedge clk);
    chk("R1", bclk_out, 1'b1);
    chk("R1", sync_out, 1'b1);
    chk("R1", sdo, 1'b0);
    rst_n = 1'b1;
    c = 0; sL = '0; sR = '0; hL = '0; hR = '0;
  endtask

  task automatic mstep(logic ce_v, logic ld, logic [15:0] nl, logic [15:0] nr);
    ce = ce_v; load = ld; left_in = nl; right_in = nr;
    sync_in = ~sync_in; bclk_in = c[1];
    @(posedge clk);
    if (ce_v) begin
      c++;
      if (c % 128 == 0) begin hL = sL; hR = sR; end
    end
    if (ld) begin sL = nl; sR = nr; end
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic mcheck(string dtag, logic stalled);
    int s = (c / 2) % 64;
    chk(stalled ? "R2" : "R2", bclk_out, (c % 2) == 0);
    chk("R4", sync_out, e_sync(s, mode_sync_coinc));
    chk(dtag, sdo, e_bit(s, mode_rjust, hL, hR));
    chk(e_act(s, mode_rjust) ? "R3" : "R8", sdo_oe, e_act(s, mode_rjust) | mode_drive_low);
    chk("R9", sync_oe & bclk_oe, 1'b1);
  endtask

  task automatic run_master(logic [34:0] v, logic tear);
    logic [15:0] l2 = ~v[31:16];
    logic [15:0] r2 = {v[7:0], v[15:8]};
    string dtag;
    do_reset(1'b0, v[34], v[33], v[32]);
    dtag = tear ? "R7" : (v[33] ? "R6" : "R5");
    for (int st = 0; c < 384; st++) begin
      logic stall = (st % 9 == 4);
      logic ld = (st == 1) || (tear && c == 200 && !stall);
      mstep(!stall, ld, (st == 1) ? v[31:16] : l2, (st == 1) ? v[15:0] : r2);
      mcheck(dtag, stall);
    end
  endtask

  task automatic run_slave();
    int pre = 5;
    logic [15:0] L = 16'hC6A1, R = 16'h5E37;
    do_reset(1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    load = 1'b1; left_in = L; right_in = R;
    @(negedge clk);
    load = 1'b0;
    chk("R9", sync_oe | bclk_oe, 1'b0);
    for (int i = 0; i < 2 * (pre + 110) + 4; i++) begin
      if (i >= 3 && ((i - 3) % 2 == 0)) begin
        int g = (i - 3) / 2;
        if (g >= pre) begin
          int k = (g - pre) % 64;
          c = g;
          chk((k == 0) ? "R11" : "R10", sdo, e_bit(k, 1'b0, L, R));
          chk("R10", sdo_oe, e_act(k, 1'b0));
        end
      end
      begin
        int g = i / 2;
        bclk_in = (i % 2 == 0);
        sync_in = (g >= pre) ? (((g - pre) % 64) < 32) : 1'b0;
      end
      @(negedge clk);
    end
  endtask

  logic done = 1'b0;
  initial begin
    #1500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int vi = 0; vi < 4; vi++) run_master(VECS[vi], 1'b0);
    run_master({3'b100, 16'h0F0F, 16'hF00F}, 1'b1);
    run_slave();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule